// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Tick Generator

This block generates the clock enables for an asynchronous serial port. A free-running bus clock feeds two dividers in series. The first divides by a small odd-leaning ratio (1, 3, 4, 9 or 13). The second divides that result by a power of two from 1 to 128. The combined output is a single-cycle enable at sixteen times the bit rate, which the receiver uses for oversampling. A fixed divide-by-16 counter driven by that enable gives a single-cycle bit-rate enable for the transmitter.

Software sets both ratios through one 8-bit configuration register and can read the register back. The register also holds a test bit. While that bit is set, all three counters are held cleared, so the tick phase can be restarted from a known point. Each counter reloads only when it expires, so a new setting never cuts a count short and never produces a stray pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both tick outputs are low and register bits [7:3] read as zero. The rate field [2:0] keeps its value through `rst` and is zero at power-up.
- R2: The register layout is: [7] counter clear, [6] reads zero, [5:3] prescale code, [2:0] rate code. A write stores all bits except [6], and `cfg_rdata` returns the stored fields in the same positions.
- R3: Prescale code to first-stage ratio: codes 000 and 100 give 1, 001 gives 3, 010 and 110 give 4, 011 and 111 give 13, and 101 gives 9.
- R4: The second stage divides the first-stage pulses by 2 to the power of the rate code, so the ratio is 1, 2, 4 and so on up to 128.
- R5: In steady state, `tick_x16` is a single-cycle pulse with a period of prescale ratio × 2^rate bus clock cycles.
- R6: `tick_bit` pulses once for every 16 `tick_x16` pulses. Each `tick_bit` pulse comes one cycle after a `tick_x16` pulse, and its period is 16 × the `tick_x16` period.
- R7: While bit [7] is set, neither tick output pulses. After a write clears bit [7] on clock edge W, `tick_x16` first pulses after edge W+2 and `tick_bit` after edge W+3.
- R8: A change to the rate fields takes effect only at the next reload. The `tick_x16` interval during which the write lands keeps the old length, and the interval after it has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read-back of the configuration register |
| tick_x16 | output | 1 | Single-cycle enable at 16× bit rate |
| tick_bit | output | 1 | Single-cycle enable at the bit rate |

## Verification
The hardest case to reach is a rate write that lands in the middle of a second-stage count. The old count must finish at full length, and the new ratio must appear only from the next interval. The bench holds the prescaler at ratio 1 and waits for a `tick_x16` pulse. It then issues the write a fixed number of cycles later, inside the same measuring loop, so the straddled interval and the one after it can each be compared with an exact expected length. The clear-bit restart is driven the same way: the bench counts edges from the releasing write.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CFG_W   = 8;
  localparam int PRE_W   = 4;   // holds largest first-stage ratio minus one
  localparam int RATE_N  = 8;   // number of binary steps in second stage
  localparam int RATE_W  = RATE_N - 1;
  localparam int OS_RATE = 16;  // oversampling factor
  localparam int OS_W    = $clog2(OS_RATE);

  typedef struct packed {
    logic       clr;
    logic       zero;
    logic [2:0] pre;
    logic [2:0] rate;
  } cfg_t;

  // first-stage ratio minus one for a prescale code
  function automatic logic [PRE_W-1:0] pre_reload(input logic [2:0] code);
    logic [PRE_W-1:0] r;
    casez (code)
      3'b?00:  r = PRE_W'(0);
      3'b001:  r = PRE_W'(2);
      3'b101:  r = PRE_W'(8);
      3'b?10:  r = PRE_W'(3);
      default: r = PRE_W'(12);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic             clr,
  output logic [2:0]       pre,
  output logic [2:0]       rate,
  output logic [CFG_W-1:0] rdata
);
  cfg_t       wcfg;
  logic       clr_q;
  logic [2:0] pre_q;
  logic [2:0] rate_q = '0;  // no reset; defined power-up value

  assign wcfg = cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= 1'b0;
      pre_q <= '0;
    end else if (wr) begin
      clr_q <= wcfg.clr;
      pre_q <= wcfg.pre;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !rst) rate_q <= wcfg.rate;
  end

  assign clr   = clr_q;
  assign pre   = pre_q;
  assign rate  = rate_q;
  assign rdata = {clr_q, 1'b0, pre_q, rate_q};

  // R1
  reset_fields_chk: assert property (@(posedge clk) rst |=> (!clr_q && pre_q == 3'd0));
endmodule

// File: rtl/baud_div_stage.sv
module baud_div_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en) begin
        if (cnt == '0) begin
          cnt  <= reload;
          tick <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R4
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R7
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && $past(clr)) |-> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             tick_x16,
  output logic             tick_bit
);
  logic              clr;
  logic [2:0]        pre_code;
  logic [2:0]        rate_code;
  logic              pre_tick;
  logic [PRE_W-1:0]  pre_load;
  logic [RATE_W-1:0] rate_load;
  logic [OS_W-1:0]   os_load;

  baud_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .clr   (clr),
    .pre   (pre_code),
    .rate  (rate_code),
    .rdata (cfg_rdata)
  );

  assign pre_load  = pre_reload(pre_code);
  assign rate_load = ~({RATE_W{1'b1}} << rate_code);
  assign os_load   = OS_W'(OS_RATE - 1);

  baud_div_stage #(.CNT_W(PRE_W)) u_pre (
    .clk (clk), .rst (rst), .clr (clr), .en (1'b1),
    .reload (pre_load), .tick (pre_tick)
  );

  baud_div_stage #(.CNT_W(RATE_W)) u_rate (
    .clk (clk), .rst (rst), .clr (clr), .en (pre_tick),
    .reload (rate_load), .tick (tick_x16)
  );

  baud_div_stage #(.CNT_W(OS_W)) u_os (
    .clk (clk), .rst (rst), .clr (clr), .en (tick_x16),
    .reload (os_load), .tick (tick_bit)
  );

  // R6
  bit_follows_x16_chk: assert property (@(posedge clk) disable iff (rst)
    tick_bit |-> $past(tick_x16));

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    rst |=> (!tick_x16 && !tick_bit));
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tick_x16, tick_bit;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_x16(tick_x16), .tick_bit(tick_bit)
  );

  function automatic int pre_ratio(input int code);
    case (code & 7)
      0, 4:    return 1;
      1:       return 3;
      2, 6:    return 4;
      5:       return 9;
      default: return 13;
    endcase
  endfunction

  function automatic int x16_period(input int pcode, input int rcode);
    return pre_ratio(pcode) * (1 << rcode);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_x16(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_x16 && n < 40000);
  endtask

  task automatic wait_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_bit && n < 40000);
  endtask

  task automatic run_combo(input int pc, input int rc, input bit with_bit);
    int n, p;
    wr_cfg(8'((pc << 3) | rc));
    wait_x16(n); wait_x16(n);
    wait_x16(n);
    p = x16_period(pc, rc);
    chk($sformatf("R3 R4 R5 period pre=%0d rate=%0d", pc, rc), n, p);
    if (p > 1) begin
      @(negedge clk);
      chk("R5 single-cycle pulse", int'(tick_x16), 0);
    end
    if (with_bit) begin
      wait_bit(n); wait_bit(n);
      chk($sformatf("R6 bit period pre=%0d rate=%0d", pc, rc), n, 16 * p);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, k, first16, firstbit, pulses;
    void'($urandom(32'd1729));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 x16 low in reset", int'(tick_x16), 0);
    chk("R1 bit low in reset", int'(tick_bit), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", int'(cfg_rdata), 0);
    chk("R1 ticks after reset", int'(tick_x16 | tick_bit), 0);

    // R2: read-back and bit 6
    wr_cfg(8'hFF);
    chk("R2 readback all ones", int'(cfg_rdata), 8'hBF);
    wr_cfg(8'h40);
    chk("R2 bit6 ignored", int'(cfg_rdata), 0);
    wr_cfg(8'h2D);
    chk("R2 readback fields", int'(cfg_rdata), 8'h2D);

    // R1: rate field survives reset
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rate kept through reset", int'(cfg_rdata), 8'h05);

    // R3 R4 R5 R6: full sweep
    for (int pc = 0; pc < 8; pc++)
      for (int rc = 0; rc < 8; rc++)
        run_combo(pc, rc, x16_period(pc, rc) <= 32);

    // random configurations
    for (int i = 0; i < 20; i++) begin
      int pc, rc;
      pc = int'($urandom_range(7, 0));
      rc = int'($urandom_range(7, 0));
      while (x16_period(pc, rc) > 800) rc--;
      run_combo(pc, rc, x16_period(pc, rc) <= 64);
    end

    // R7: clear bit holds counters
    wr_cfg(8'h80 | 8'h12);
    pulses = 0;
    repeat (200) begin
      @(negedge clk);
      if (tick_x16 || tick_bit) pulses++;
    end
    chk("R7 no pulses while clear", pulses, 0);
    wr_cfg(8'h12);
    first16 = 0; firstbit = 0;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      if (tick_x16 && first16 == 0) first16 = j;
      if (tick_bit && firstbit == 0) firstbit = j;
    end
    chk("R7 first x16 after release", first16, 2);
    chk("R7 first bit after release", firstbit, 3);

    // R8: rate change mid-interval
    wr_cfg(8'h04);            // pre 1, rate 16
    wait_x16(n); wait_x16(n);
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 5) begin cfg_wr = 1'b1; cfg_wdata = 8'h01; end
      else cfg_wr = 1'b0;
    end while (!tick_x16 && k < 40000);
    chk("R8 straddled interval keeps old length", k, 16);
    wait_x16(n);
    chk("R8 next interval uses new length", n, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule